// File: doc/BRIEF.md
# Segment Display Holding Stage

This block is the display output stage of a small calculator-style processor. It drives ten segment lines from ten holding cells, one per line. Lines 0 to 6 carry the seven-segment shapes `a` to `g`, line 7 is the decimal point, and lines 8 and 9 are discrete marks used only by special symbols. On each load, every cell except the point takes its new value from one of two places. Normally that is the seven-segment decode of a 4-bit accumulator value. When a special symbol is selected, it is a caller-supplied bit pattern instead. The point cell always takes the value of an internal carry flag. The carry flag can be set, cleared, held, or loaded from the adder's carry output, and its value is visible on a pin so it can be tested.

Every cell has a shared active-low load strobe and a per-cell asynchronous force input. While the strobe is low at a clock edge, each cell captures its data-enable level. Data-enable high clears the cell and low sets it. While the strobe is high, the cells keep their state. The force input turns its cell on at once, and the cell stays on after the force is released until a later load clears it. All inputs are plain strobes and levels, so nothing here applies back-pressure. A load is accepted on every clock edge where the strobe is low. The pads use negative logic, and a parameter selects whether pin levels are inverted from the internal state.

Top module: `seg_out_stage`

## Requirements
- R1: A synchronous reset clears every holding cell and the carry flag. With the default active-low pins, all ten pins read 1 after reset.
- R2: With the strobe `load_n` low at a clock edge and `sym_sel` low, accumulator values 0 to 9 load the digit shapes onto lines 0 to 6 (bit 0 is `a`, through bit 6 is `g`). The shapes, written as the hex value of bits 6..0, are 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. Lines 8 and 9 load off.
- R3: With `sym_sel` low, accumulator values 10 to 15 load all of lines 0 to 6, 8 and 9 off.
- R4: With `sym_sel` high, every line except the point loads the matching bit of `sym_bits`, whatever the accumulator holds.
- R5: The point cell (line 7) loads the carry flag value held before that same clock edge, and it ignores `sym_bits[7]`.
- R6: While `load_n` is high, the cells keep their state whatever the accumulator, `sym_sel` and `sym_bits` do.
- R7: Raising `force_set[i]` turns line i on without waiting for a clock edge. The line stays on after the force is released until a later load clears it.
- R8: A force that is high at a clock edge overrides both a load and a reset at that edge, and the line stays on.
- R9: `cf_op` codes: 0 holds, 1 sets, 2 clears, and 3 loads `adder_carry` into the carry flag at the clock edge. `carry_flag` shows the flag.
- R10: With `PIN_ACTIVE_LOW`=1, each pin is the inverse of its cell state. On means pin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc | input | 4 | Accumulator value to decode |
| sym_sel | input | 1 | Selects the special-symbol pattern instead of the decode |
| sym_bits | input | 10 | Special-symbol pattern, one bit per line (bit 7 unused) |
| load_n | input | 1 | Load strobe, active low |
| force_set | input | 10 | Asynchronous force-on, one bit per line |
| cf_op | input | 2 | Carry flag operation: 0 hold, 1 set, 2 clear, 3 load |
| adder_carry | input | 1 | Carry output of the adder |
| carry_flag | output | 1 | Current carry flag, for testing |
| seg_pin | output | 10 | Segment pin levels |

## Verification
Some behaviours are checked by assertions on every cycle:
- the carry flag follows each set, clear and load operation;
- a cell stays on while its force is high, including when a load is requested;
- a cell with neither load nor force keeps its state;
- the point cell captures the previous carry value;
- a blank code loads nothing onto the shape lines.

The bench's scenarios cover what no single cycle can show:
- the full digit table and special-symbol patterns observed at the pins;
- a forced cell remaining on after the force is gone;
- accumulator and pattern changes being ignored while the strobe is high;
- the pin inversion against the reset state.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    CF_HOLD = 2'd0,
    CF_SET  = 2'd1,
    CF_CLR  = 2'd2,
    CF_LOAD = 2'd3
  } cf_op_e;

  // number of shape lines driven by the digit decode
  localparam int SHAPE_W = 7;
  // largest accumulator value with a digit shape
  localparam int MAX_DIGIT = 9;
endpackage

// File: rtl/seg_carry_flag.sv
module seg_carry_flag
  import seg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cf_op_e op,
  input  logic   adder_carry,
  output logic   flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else begin
      unique case (op)
        CF_SET:  flag <= 1'b1;
        CF_CLR:  flag <= 1'b0;
        CF_LOAD: flag <= adder_carry;
        default: flag <= flag;
      endcase
    end
  end

  a_r9_set: assert property (@(posedge clk) disable iff (rst)
    (op == CF_SET) |=> flag);
  a_r9_clr: assert property (@(posedge clk) disable iff (rst)
    (op == CF_CLR) |=> !flag);
  a_r9_load: assert property (@(posedge clk) disable iff (rst)
    (op == CF_LOAD) |=> (flag == $past(adder_carry)));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (op == CF_HOLD) |=> $stable(flag));
endmodule

// File: rtl/seg_digit_decode.sv
module seg_digit_decode
  import seg_pkg::*;
#(
  parameter int ACC_W  = 4,
  parameter int NSEG   = 10,
  parameter int PT_IDX = 7
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             sym_sel,
  input  logic [NSEG-1:0]  sym_bits,
  output logic [NSEG-1:0]  pattern
);
  logic [SHAPE_W-1:0] shape;
  int unsigned        acc_val;

  always_comb begin
    acc_val = 32'(acc);
    unique case (acc_val)
      0: shape = 7'h3F;
      1: shape = 7'h06;
      2: shape = 7'h5B;
      3: shape = 7'h4F;
      4: shape = 7'h66;
      5: shape = 7'h6D;
      6: shape = 7'h7D;
      7: shape = 7'h07;
      8: shape = 7'h7F;
      9: shape = 7'h6F;
      default: shape = '0;
    endcase
  end

  always_comb begin
    pattern = '0;
    if (sym_sel) begin
      pattern = sym_bits;
    end else begin
      pattern[SHAPE_W-1:0] = shape;
    end
    // the point line is fed by the carry flag, never by the decode
    pattern[PT_IDX] = 1'b0;
  end

  always_comb begin
    if (!sym_sel && acc_val > MAX_DIGIT) begin
      a_r3_blank_code: assert (pattern == '0);
    end
  end
endmodule

// File: rtl/seg_hold_cell.sv
module seg_hold_cell (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  input  logic clr_en,
  input  logic force_on,
  output logic q
);
  always_ff @(posedge clk or posedge force_on) begin
    if (force_on) begin
      q <= 1'b1;
    end else if (rst) begin
      q <= 1'b0;
    end else if (!strobe_n) begin
      q <= !clr_en;
    end
  end

  a_r7_force_on: assert property (@(posedge clk) disable iff (rst)
    force_on |-> q);
  a_r8_force_beats_load: assert property (@(posedge clk)
    (force_on && !strobe_n) |=> (q || rst));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (strobe_n && !force_on) |=> (q || (q == $past(q))));
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_pkg::*;
#(
  parameter int ACC_W          = 4,
  parameter int NSEG           = 10,
  parameter int PT_IDX         = 7,
  parameter bit PIN_ACTIVE_LOW = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc,
  input  logic             sym_sel,
  input  logic [NSEG-1:0]  sym_bits,
  input  logic             load_n,
  input  logic [NSEG-1:0]  force_set,
  input  logic [1:0]       cf_op,
  input  logic             adder_carry,
  output logic             carry_flag,
  output logic [NSEG-1:0]  seg_pin
);
  localparam logic [NSEG-1:0] PIN_FLIP = {NSEG{PIN_ACTIVE_LOW}};

  logic [NSEG-1:0] dec_pattern;
  logic [NSEG-1:0] next_state;
  logic [NSEG-1:0] cell_q;
  cf_op_e          op_q;

  assign op_q = cf_op_e'(cf_op);

  seg_carry_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .op          (op_q),
    .adder_carry (adder_carry),
    .flag        (carry_flag)
  );

  seg_digit_decode #(
    .ACC_W  (ACC_W),
    .NSEG   (NSEG),
    .PT_IDX (PT_IDX)
  ) u_dec (
    .acc      (acc),
    .sym_sel  (sym_sel),
    .sym_bits (sym_bits),
    .pattern  (dec_pattern)
  );

  always_comb begin
    next_state = dec_pattern;
    next_state[PT_IDX] = carry_flag;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_cell
    seg_hold_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .strobe_n (load_n),
      .clr_en   (!next_state[i]),
      .force_on (force_set[i]),
      .q        (cell_q[i])
    );
  end

  assign seg_pin = cell_q ^ PIN_FLIP;

  a_r5_point_from_flag: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !force_set[PT_IDX]) |=>
      (cell_q[PT_IDX] == $past(carry_flag)) || force_set[PT_IDX]);
  a_r1_reset_clears: assert property (@(posedge clk)
    (rst && force_set == '0) |=> ((cell_q & ~force_set) == '0) && !carry_flag);
endmodule

// File: tb/tb_seg_out_stage.sv
module tb_seg_out_stage;
  localparam int NSEG = 10;
  localparam int PT   = 7;

  logic            clk = 1'b0;
  logic            rst;
  logic [3:0]      acc;
  logic            sym_sel;
  logic [NSEG-1:0] sym_bits;
  logic            load_n;
  logic [NSEG-1:0] force_set;
  logic [1:0]      cf_op;
  logic            adder_carry;
  logic            carry_flag;
  logic [NSEG-1:0] seg_pin;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  seg_out_stage dut (
    .clk(clk), .rst(rst), .acc(acc), .sym_sel(sym_sel), .sym_bits(sym_bits),
    .load_n(load_n), .force_set(force_set), .cf_op(cf_op),
    .adder_carry(adder_carry), .carry_flag(carry_flag), .seg_pin(seg_pin)
  );

  function automatic logic [6:0] digit_shape(int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic chk_pins(string req, logic [NSEG-1:0] exp_state);
    checks++;
    if (seg_pin !== ~exp_state) begin
      errors++;
      $display("FAIL %s pins got %b expected %b", req, seg_pin, ~exp_state);
    end
  endtask

  task automatic chk_flag(string req, logic exp);
    checks++;
    if (carry_flag !== exp) begin
      errors++;
      $display("FAIL %s carry got %b expected %b", req, carry_flag, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NSEG-1:0] exp;
    logic [NSEG-1:0] pat;
    logic            fl;
    rst = 1; acc = 0; sym_sel = 0; sym_bits = 0; load_n = 1;
    force_set = 0; cf_op = 0; adder_carry = 0;
    @(negedge clk);
    step();
    // R1 and R10: all cells off -> all pins high
    chk_pins("R1/R10", '0);
    chk_flag("R1", 1'b0);
    rst = 0;
    step();

    // R2, R3, R5, R9: sweep accumulator with carry loaded from adder
    for (int v = 0; v < 16; v++) begin
      fl = v[0] ^ v[2];
      cf_op = 2'd3; adder_carry = fl; load_n = 1;
      step();
      chk_flag("R9 load", fl);
      cf_op = 2'd0; adder_carry = ~fl; acc = 4'(v); sym_sel = 0; load_n = 0;
      step();
      exp = '0;
      exp[6:0] = digit_shape(v);
      exp[PT] = fl;
      chk_pins(v < 10 ? "R2" : "R3", exp);
      chk_flag("R9 hold", fl);
    end

    // R4, R5, R9: special-symbol patterns with set/clear carry
    for (int k = 0; k < 48; k++) begin
      pat = NSEG'((k * 37 + 5) ^ (k << 4));
      cf_op = k[0] ? 2'd1 : 2'd2; load_n = 1;
      step();
      chk_flag(k[0] ? "R9 set" : "R9 clr", k[0]);
      cf_op = 2'd0; sym_sel = 1; sym_bits = pat; acc = 4'(k); load_n = 0;
      step();
      exp = pat;
      exp[PT] = k[0];
      chk_pins("R4/R5", exp);
    end

    // R6: strobe high, change everything, state holds
    load_n = 1;
    for (int k = 0; k < 8; k++) begin
      acc = 4'(k * 3); sym_sel = k[0]; sym_bits = ~exp ^ NSEG'(k);
      cf_op = 2'd0;
      step();
      chk_pins("R6", exp);
    end

    // clear everything: blank code, carry cleared
    cf_op = 2'd2;
    step();
    cf_op = 2'd0; sym_sel = 0; acc = 4'd12; load_n = 0;
    step();
    chk_pins("R3 blank", '0);
    load_n = 1;

    // R7: force each line asynchronously, then hold after release
    for (int i = 0; i < NSEG; i++) begin
      #5 force_set[i] = 1'b1;
      #1;
      exp = '0; exp[i] = 1'b1;
      chk_pins("R7 immediate", exp);
      @(negedge clk);
      force_set[i] = 1'b0;
      step();
      chk_pins("R7 retained", exp);
      load_n = 0;
      step();
      load_n = 1;
      chk_pins("R7 cleared by load", '0);
    end

    // R8: force with load of zero, and force with reset
    force_set = 10'b1000000001; load_n = 0;
    step();
    force_set = '0;
    load_n = 1;
    step();
    chk_pins("R8 load", 10'b1000000001);
    force_set = 10'b0000100000; rst = 1;
    step();
    force_set = '0; rst = 0;
    step();
    chk_pins("R8 reset", 10'b0000100000);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule